// File: doc/BRIEF.md
# Handshaked Control-Channel Byte Receiver

This block is the receiving end of a byte-wide control channel that rides on a framed serial link. Once per frame the link delivers a strobe together with a parallel data byte and a one-bit transmit strobe (MX, active low). The receiver answers every frame with a one-bit acknowledge (MR, also active low). It stores accepted bytes in a data register that the host can read. It reports byte arrival and end of message through sticky status bits that are cleared when read.

The host steers the transfer with two level inputs. The receive-enable input lets the block accept and acknowledge bytes. The interrupt-enable input gates every status event except the first byte of a message. The first byte of a message is always latched and reported, so the host can inspect it before it commits to the transfer. After that, each byte is acknowledged only once the host has read the data register. The acknowledge is one inactive MR frame followed by MR active again.

When MX stays inactive for two consecutive frames, the block reports the end of the message. Dropping the receive-enable input forces MR inactive. If this happens during a transfer, MR stays inactive for a minimum number of frames, and the transmitter reads that as an abort.

Top module: `mon_rx`

## Requirements
- R1: While and right after the synchronous reset `rst`, `mr_o`=1, `chan_active`=0, `stat_ready`=0, `stat_end`=0 and `irq`=0.
- R2: With `chan_active`=0, a frame with `rx_mx`=0 that follows a frame with `rx_mx`=1 copies `rx_byte` into `data_q` and sets `chan_active`=1. It also sets `stat_ready`=1 whatever `int_en` is. While `ctrl_en`=0, `mr_o` stays 1.
- R3: With `chan_active`=1 and `ctrl_en`=1, `mr_o` becomes 0 at the next frame strobe.
- R4: With `ctrl_en`=1, `mr_o`=0 and no unread byte, a frame with `rx_mx`=0 after a frame with `rx_mx`=1 stores `rx_byte` into `data_q`. The same frame sets `stat_ready` only when `int_en`=1.
- R5: While a stored byte has not been read through `data_rd`, MX transitions are ignored: `data_q` keeps its value, `stat_ready` is not set and `mr_o` stays 0.
- R6: After a `data_rd` pulse, the next frame drives `mr_o`=1 for exactly that one frame, and the frame after it drives `mr_o`=0.
- R7: While `chan_active`=1, `rx_mx`=1 in two consecutive frames sets `stat_end` when `int_en`=1. A single inactive frame between bytes does not set it.
- R8: If `ctrl_en`=0 while `mr_o`=0, the next frame drives `mr_o`=1. MR then stays 1 for at least 2 frames in total, even if `ctrl_en` returns to 1 in the meantime. After that it goes back to 0 when `ctrl_en`=1.
- R9: After the end of a message, `chan_active` drops to 0 one clock after `ctrl_en` is 0.
- R10: `stat_ready` and `stat_end` are sticky. A `stat_rd` pulse clears both, unless a new event sets them in the same cycle. `irq` is the OR of the two.
- R11: `mr_o` changes only on clock edges where `frame_stb`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe marking a received frame |
| rx_byte | input | DATA_W | Data byte carried by the frame |
| rx_mx | input | 1 | Transmit strobe bit of the frame, active low |
| ctrl_en | input | 1 | Host receive enable |
| int_en | input | 1 | Host interrupt enable for status after the first byte |
| data_rd | input | 1 | One-cycle pulse: host has read `data_q` |
| stat_rd | input | 1 | One-cycle pulse: host reads and clears status |
| mr_o | output | 1 | Acknowledge bit sent back each frame, active low |
| data_q | output | DATA_W | Last stored byte |
| stat_ready | output | 1 | Sticky byte-received status |
| stat_end | output | 1 | Sticky end-of-message status |
| chan_active | output | 1 | A message is in progress |
| irq | output | 1 | OR of the status bits |

## Verification
A wrong acknowledge state shows up on `mr_o` at the very next frame strobe: a missing gap frame, or a gap that lasts too long. A transmitter that follows the handshake would then stall or resend a byte. A stuck unread-byte flag shows up as the next byte failing to reach `data_q` one frame after its MX edge. A lost end-of-message flag shows up as `stat_end` staying low after the second quiet frame, and as `chan_active` never dropping when the receive enable is cleared. A shortened abort hold is visible on `mr_o` within two frames of the enable dropping.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_ON   = 2'd1,
    ACK_GAP  = 2'd2,
    ACK_HOLD = 2'd3
  } ack_st_e;

  // MX is active low: a new byte is marked by inactive then active
  function automatic logic mx_new_byte(input logic prev_mx, input logic cur_mx);
    return prev_mx & ~cur_mx;
  endfunction

  // two inactive frames in a row close the message
  function automatic logic mx_quiet_pair(input logic prev_mx, input logic cur_mx);
    return prev_mx & cur_mx;
  endfunction

endpackage

// File: rtl/mon_frame_sampler.sv
module mon_frame_sampler
  import mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic rx_mx,
  output logic mx_fall,
  output logic mx_quiet2
);

  logic mx_prev;

  always_ff @(posedge clk) begin
    if (rst)            mx_prev <= 1'b1;
    else if (frame_stb) mx_prev <= rx_mx;
  end

  assign mx_fall   = frame_stb & mx_new_byte(mx_prev, rx_mx);
  assign mx_quiet2 = frame_stb & mx_quiet_pair(mx_prev, rx_mx);

  // an edge and a quiet pair cannot both be seen in one frame (R4, R7)
  p_edge_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(mx_fall && mx_quiet2));

endmodule

// File: rtl/mon_ack_ctrl.sv
module mon_ack_ctrl
  import mon_pkg::*;
#(
  parameter int HOLD_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic ctrl_en,
  input  logic chan_active,
  input  logic rd_pend,
  output logic mr_o,
  output logic ack_on,
  output logic gap_enter
);

  localparam int CW = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_FRAMES);

  ack_st_e       st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          go_on;

  assign go_on = ctrl_en & chan_active;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (frame_stb) begin
      unique case (st)
        ACK_IDLE: if (go_on) st_nx = ACK_ON;
        ACK_ON: begin
          if (!go_on) begin
            st_nx  = ACK_HOLD;
            cnt_nx = CW'(1);
          end else if (rd_pend) begin
            st_nx = ACK_GAP;
          end
        end
        ACK_GAP: begin
          if (!go_on) begin
            st_nx  = ACK_HOLD;
            cnt_nx = CW'(2);
          end else begin
            st_nx = ACK_ON;
          end
        end
        ACK_HOLD: begin
          if (cnt < HOLD_MAX) cnt_nx = cnt + CW'(1);
          else                st_nx  = go_on ? ACK_ON : ACK_IDLE;
        end
        default: st_nx = ACK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ACK_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign mr_o      = (st != ACK_ON);
  assign ack_on    = (st == ACK_ON);
  assign gap_enter = frame_stb & (st == ACK_ON) & go_on & rd_pend;

  p_mr_frame_only_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(mr_o));

  p_hold_min_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && st == ACK_HOLD && cnt < HOLD_MAX) |=> mr_o);

  p_gap_single_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && st == ACK_GAP && go_on) |=> !mr_o);

endmodule

// File: rtl/mon_status.sv
module mon_status (
  input  logic clk,
  input  logic rst,
  input  logic set_rdy,
  input  logic set_end,
  input  logic clr,
  output logic rdy,
  output logic endf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy  <= 1'b0;
      endf <= 1'b0;
    end else begin
      rdy  <= set_rdy | (rdy & ~clr);
      endf <= set_end | (endf & ~clr);
    end
  end

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_rdy && !set_end) |=> (!rdy && !endf));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (rdy && !clr) |=> rdy);

endmodule

// File: rtl/mon_rx.sv
module mon_rx
  import mon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HOLD_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_mx,
  input  logic              ctrl_en,
  input  logic              int_en,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic              mr_o,
  output logic [DATA_W-1:0] data_q,
  output logic              stat_ready,
  output logic              stat_end,
  output logic              chan_active,
  output logic              irq
);

  logic mx_fall, mx_quiet2;
  logic ack_on, gap_enter;
  logic end_seen, ack_wait, rd_pend;
  logic first_evt, byte_evt, end_evt, close_evt;

  mon_frame_sampler u_smp (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .rx_mx     (rx_mx),
    .mx_fall   (mx_fall),
    .mx_quiet2 (mx_quiet2)
  );

  mon_ack_ctrl #(.HOLD_FRAMES(HOLD_FRAMES)) u_ack (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .ctrl_en     (ctrl_en),
    .chan_active (chan_active),
    .rd_pend     (rd_pend),
    .mr_o        (mr_o),
    .ack_on      (ack_on),
    .gap_enter   (gap_enter)
  );

  // named events, used by the state below and by the assertions
  assign first_evt = mx_fall & ~chan_active;
  assign byte_evt  = mx_fall & chan_active & ctrl_en & ack_on
                   & ~ack_wait & ~rd_pend & ~end_seen;
  assign end_evt   = mx_quiet2 & chan_active & ~end_seen;
  assign close_evt = chan_active & end_seen & ~ctrl_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= '0;
      chan_active <= 1'b0;
      end_seen    <= 1'b0;
      ack_wait    <= 1'b0;
      rd_pend     <= 1'b0;
    end else if (close_evt) begin
      chan_active <= 1'b0;
      end_seen    <= 1'b0;
      ack_wait    <= 1'b0;
      rd_pend     <= 1'b0;
    end else begin
      if (first_evt) begin
        data_q      <= rx_byte;
        chan_active <= 1'b1;
      end
      if (byte_evt) begin
        data_q   <= rx_byte;
        ack_wait <= 1'b1;
      end
      if (end_evt) end_seen <= 1'b1;
      if (data_rd && ack_wait) begin
        ack_wait <= 1'b0;
        rd_pend  <= 1'b1;
      end
      if (gap_enter || !ctrl_en) rd_pend <= 1'b0;
    end
  end

  mon_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_rdy (first_evt | (byte_evt & int_en)),
    .set_end (end_evt & int_en),
    .clr     (stat_rd),
    .rdy     (stat_ready),
    .endf    (stat_end)
  );

  assign irq = stat_ready | stat_end;

  p_first_r2: assert property (@(posedge clk) disable iff (rst)
    first_evt |=> (stat_ready && chan_active));

  p_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (byte_evt && int_en) |=> stat_ready);

  p_unread_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_wait && !close_evt) |=> $stable(data_q));

  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    (end_evt && int_en) |=> stat_end);

  p_close_r9: assert property (@(posedge clk) disable iff (rst)
    close_evt |=> !chan_active);

endmodule

// File: tb/mon_rx_tb.sv
module mon_rx_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_stb = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          rx_mx = 1'b1;
  logic          ctrl_en = 1'b0;
  logic          int_en = 1'b0;
  logic          data_rd = 1'b0;
  logic          stat_rd = 1'b0;
  logic          mr_o, stat_ready, stat_end, chan_active, irq;
  logic [DW-1:0] data_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  mon_rx #(.DATA_W(DW), .HOLD_FRAMES(2)) u_dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_byte(rx_byte),
    .rx_mx(rx_mx), .ctrl_en(ctrl_en), .int_en(int_en), .data_rd(data_rd),
    .stat_rd(stat_rd), .mr_o(mr_o), .data_q(data_q), .stat_ready(stat_ready),
    .stat_end(stat_end), .chan_active(chan_active), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected status after a later byte: reported only with interrupts enabled
  function automatic logic exp_ready(input logic ie);
    return ie;
  endfunction

  function automatic logic exp_irq(input logic r, input logic e);
    return r | e;
  endfunction

  task automatic frame(input logic mx, input logic [DW-1:0] b);
    @(negedge clk);
    frame_stb = 1'b1; rx_mx = mx; rx_byte = b;
    @(negedge clk);
    frame_stb = 1'b0;
    rx_byte = $urandom;
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic clr_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic end_and_close(input logic ie);
    frame(1'b1, 8'h00);
    chk("R7 single quiet frame", stat_end, 1'b0);
    frame(1'b1, 8'h00);
    chk("R7 end status", stat_end, ie);
    chk("R10 irq", irq, exp_irq(stat_ready, ie));
    @(negedge clk); ctrl_en = 1'b0;
    @(negedge clk);
    chk("R9 active drop", chan_active, 1'b0);
    frame(1'b1, 8'h00);
    frame(1'b1, 8'h00);
    frame(1'b1, 8'h00);
    clr_stat();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] b0, bi, held;
    logic ie;
    void'($urandom(32'h5eed_2091));
    repeat (3) @(negedge clk);
    chk("R1 mr", mr_o, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mr", mr_o, 1'b1);
    chk("R1 active", chan_active, 1'b0);
    chk("R1 ready", stat_ready, 1'b0);
    chk("R1 end", stat_end, 1'b0);
    chk("R1 irq", irq, 1'b0);

    for (int it = 0; it < 4; it++) begin
      ie = (it == 0) ? 1'b0 : ((it == 1) ? 1'b1 : 1'($urandom));
      int_en = ie;
      b0 = $urandom;
      frame(1'b1, 8'h00);
      frame(1'b1, 8'h00);
      frame(1'b0, b0);
      chk("R2 data", data_q, b0);
      chk("R2 ready ungated", stat_ready, 1'b1);
      chk("R2 active", chan_active, 1'b1);
      chk("R2 mr idle", mr_o, 1'b1);
      frame(1'b0, b0);
      chk("R2 mr without enable", mr_o, 1'b1);
      clr_stat();
      chk("R10 cleared", stat_ready, 1'b0);
      chk("R10 irq cleared", irq, 1'b0);
      @(negedge clk); ctrl_en = 1'b1;
      frame(1'b0, b0);
      chk("R3 first ack", mr_o, 1'b0);

      for (int k = 0; k < 2 + int'($urandom_range(0, 3)); k++) begin
        bi = $urandom;
        frame(1'b1, bi);
        frame(1'b0, bi);
        chk("R4 data", data_q, bi);
        chk("R4 ready gate", stat_ready, exp_ready(ie));
        held = bi;
        clr_stat();
        frame(1'b1, 8'hA5);
        frame(1'b0, 8'h5A);
        chk("R5 data held", data_q, held);
        chk("R5 no ready", stat_ready, 1'b0);
        chk("R5 mr active", mr_o, 1'b0);
        pulse_rd();
        repeat (3) @(negedge clk);
        chk("R11 mr between frames", mr_o, 1'b0);
        frame(1'b0, 8'h5A);
        chk("R6 gap frame", mr_o, 1'b1);
        frame(1'b0, 8'h5A);
        chk("R6 ack again", mr_o, 1'b0);
      end

      if (it == 2) begin
        // abort while a transfer is running
        @(negedge clk); ctrl_en = 1'b0;
        frame(1'b0, 8'h5A);
        chk("R8 forced inactive", mr_o, 1'b1);
        @(negedge clk); ctrl_en = 1'b1;
        frame(1'b0, 8'h5A);
        chk("R8 hold second frame", mr_o, 1'b1);
        frame(1'b0, 8'h5A);
        chk("R8 resume", mr_o, 1'b0);
      end
      end_and_close(ie);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule